// File: doc/BRIEF.md
# Read-Only Small-Page NAND Device Model

This block models the device side of a small-page NAND flash that can only be read. It watches a strobe-style parallel bus: two active-low chip selects, active-low read and write strobes, active-high command and address latch enables, and an 8-bit data path. The data path is split into an input byte, an output byte and an output enable. Two independent flash dies sit behind the same bus. Each die keeps its own read mode, address-cycle count, byte pointer, ready flag and error flag.

A host selects a die and issues one of three read commands. The three commands differ in where inside a 528-byte page the column starts. The host then supplies three address bytes: a column byte and two row bytes. After that, every falling edge of the read strobe puts the byte at the pointer on the output and moves the pointer on by one. Program, erase and status operations are not modelled, and the die never reports busy. The storage is a computed read-only image. Pointers below a fill limit return a pattern byte, and every other location reads as erased.

All bus pins are sampled on the system clock. Strobe edges are found from the sampled values, so a bus change takes effect two rising clock edges later.

Top module: `nandr_read_model`

## Requirements
- R1: While reset is asserted and after it is released, `dout_en`, `ready` and `proto_err` are all zero until bus activity changes them.
- R2: The command byte 0xFF returns a die to idle. The byte 0x00 selects read mode A, 0x01 selects read mode B and 0x50 selects read mode C. Each of the three read commands restarts the address-cycle count at zero.
- R3: The first address byte sets the pointer to the byte itself in mode A, to the byte ORed with 0x100 in mode B, and to the byte ORed with 0x200 in mode C. The second address byte adds byte×528×256 to the pointer. The third address byte adds byte×528.
- R4: A falling read strobe, sampled while both latch enables are low and a die is selected, drives the byte at that die's pointer on `dout` with `dout_en` high, and then increments the pointer. The output holds its value until the next read. `dout_en` drops once both strobes are sampled high.
- R5: Storage content is a fixed function of the pointer p. If p is below FILL_LIMIT, the byte is p[7:0] XOR p[15:8] XOR 0x5A (higher bytes are also XORed in). Otherwise the byte is 0xFF.
- R6: `ce1_n` low selects die 0 and wins over `ce2_n`. `ce2_n` low alone selects die 1. With both chip selects high, strobes are ignored: no die state changes and the output stays disabled.
- R7: A selected die sets its `ready` bit when both strobes are sampled high. Bit 0 belongs to die 0 and bit 1 to die 1. A `ready` bit never falls again until reset.
- R8: A command or address byte is taken on the rising edge of the write strobe, using the latch enables and data last sampled while the strobe was low. The command latch wins over the address latch. A write pulse with neither latch high changes nothing.
- R9: An unknown command byte, an address byte while idle, or a fourth address byte sets that die's sticky `proto_err` bit and is otherwise ignored. The die keeps working afterwards.
- R10: The pointer arithmetic and the increment wrap modulo 2^PTR_W.
- R11: The two dies keep separate state. Commands, addresses and reads for one die leave the other die's pointer unchanged.
- R12: Results appear two rising clock edges after the bus change that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce1_n | input | 1 | Chip select of die 0, active low, higher priority |
| ce2_n | input | 1 | Chip select of die 1, active low |
| re_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low; bytes taken on its rise |
| ale | input | 1 | Address latch enable |
| cle | input | 1 | Command latch enable |
| din | input | 8 | Byte driven by the host |
| dout | output | 8 | Byte returned by the selected die |
| dout_en | output | 1 | High while the device drives `dout` |
| ready | output | 2 | Ready flag per die (bit index = die) |
| proto_err | output | 2 | Sticky protocol error per die |

## Verification
Each bus pin passes through one sampling register. The state, the output byte and the ready flags then update on the following edge, so every result is due on the second rising edge after the pins change. The bench drives the pins on a falling edge and holds each bus phase for three clock cycles. It samples outputs only on a falling edge after the third cycle. One check samples the ready flag right after the first edge, where it must still be low, and again after the second edge, where it must be set. Expected read bytes are queued by the driver from a pointer model kept in the bench. A monitor pops each one when the driver signals that the read strobe has been low for three cycles.

// File: rtl/nandr_pkg.sv
package nandr_pkg;

  typedef enum logic [1:0] {
    MD_IDLE  = 2'd0,
    MD_LOW   = 2'd1,
    MD_HIGH  = 2'd2,
    MD_SPARE = 2'd3
  } rd_mode_e;

  localparam logic [7:0] OP_RESET    = 8'hFF;
  localparam logic [7:0] OP_RD_LOW   = 8'h00;
  localparam logic [7:0] OP_RD_HIGH  = 8'h01;
  localparam logic [7:0] OP_RD_SPARE = 8'h50;

  localparam logic [7:0] FILL_SALT   = 8'h5A;
  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  // pattern byte of the computed image: XOR of all pointer bytes and a salt
  function automatic logic [7:0] fold_byte(input logic [31:0] p);
    return p[7:0] ^ p[15:8] ^ p[23:16] ^ p[31:24] ^ FILL_SALT;
  endfunction

endpackage

// File: rtl/nandr_bus_sampler.sv
module nandr_bus_sampler (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce1_n,
  input  logic       ce2_n,
  input  logic       re_n,
  input  logic       we_n,
  input  logic       ale,
  input  logic       cle,
  input  logic [7:0] din,
  output logic       sel_vld,
  output logic       sel_dev,
  output logic       cmd_ev,
  output logic       addr_ev,
  output logic       rd_ev,
  output logic       rel_ev,
  output logic       wr_dev,
  output logic [7:0] wr_byte
);

  logic       s_ce1_n, s_ce2_n, s_re_n, s_we_n, s_ale, s_cle;
  logic [7:0] s_din;
  logic       p_re_n, p_we_n;
  logic       h_cle, h_ale, h_sel_vld, h_dev;
  logic [7:0] h_byte;
  logic       hold_en;
  logic       we_rise;

  assign hold_en = !s_we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ce1_n <= 1'b1;
      s_ce2_n <= 1'b1;
      s_re_n  <= 1'b1;
      s_we_n  <= 1'b1;
      s_ale   <= 1'b0;
      s_cle   <= 1'b0;
      s_din   <= 8'h00;
      p_re_n  <= 1'b1;
      p_we_n  <= 1'b1;
    end else begin
      s_ce1_n <= ce1_n;
      s_ce2_n <= ce2_n;
      s_re_n  <= re_n;
      s_we_n  <= we_n;
      s_ale   <= ale;
      s_cle   <= cle;
      s_din   <= din;
      p_re_n  <= s_re_n;
      p_we_n  <= s_we_n;
    end
  end

  // latch context while the write strobe is low; used on its rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cle     <= 1'b0;
      h_ale     <= 1'b0;
      h_sel_vld <= 1'b0;
      h_dev     <= 1'b0;
      h_byte    <= 8'h00;
    end else if (hold_en) begin
      h_cle     <= s_cle;
      h_ale     <= s_ale;
      h_sel_vld <= sel_vld;
      h_dev     <= sel_dev;
      h_byte    <= s_din;
    end
  end

  always_comb begin
    sel_vld = !s_ce1_n || !s_ce2_n;
    sel_dev = s_ce1_n;                 // die 0 whenever ce1 is low
    we_rise = s_we_n && !p_we_n;
    cmd_ev  = we_rise && h_sel_vld && h_cle;
    addr_ev = we_rise && h_sel_vld && !h_cle && h_ale;
    rd_ev   = !s_re_n && p_re_n && !s_cle && !s_ale && sel_vld;
    rel_ev  = s_re_n && s_we_n;
    wr_dev  = h_dev;
    wr_byte = h_byte;
  end

endmodule

// File: rtl/nandr_dev_core.sv
module nandr_dev_core #(
  parameter int PTR_W       = 16,
  parameter int PAGE_BYTES  = 528,
  parameter int PLANE_PAGES = 256,
  parameter int HALF_COL    = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_ev,
  input  logic             addr_ev,
  input  logic             rd_ev,
  input  logic             rel_sel,
  input  logic [7:0]       byte_in,
  output logic [PTR_W-1:0] ptr,
  output logic             ready,
  output logic             err
);
  import nandr_pkg::*;

  localparam int ROW_HI = PAGE_BYTES * PLANE_PAGES;
  localparam int ROW_LO = PAGE_BYTES;

  rd_mode_e         mode_q, mode_d;
  logic [1:0]       cyc_q, cyc_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             err_q, err_d;
  logic             rdy_q, rdy_d;
  logic [31:0]      ptr_w, col_w, off_w;

  always_comb begin
    ptr_w = 32'(ptr_q);
    case (mode_q)
      MD_HIGH:  off_w = 32'(HALF_COL);
      MD_SPARE: off_w = 32'(2 * HALF_COL);
      default:  off_w = 32'd0;
    endcase
    col_w  = 32'(byte_in) | off_w;
    mode_d = mode_q;
    cyc_d  = cyc_q;
    ptr_d  = ptr_q;
    err_d  = err_q;
    rdy_d  = rdy_q | rel_sel;
    if (cmd_ev) begin
      case (byte_in)
        OP_RESET:    mode_d = MD_IDLE;
        OP_RD_LOW:   begin mode_d = MD_LOW;   cyc_d = 2'd0; end
        OP_RD_HIGH:  begin mode_d = MD_HIGH;  cyc_d = 2'd0; end
        OP_RD_SPARE: begin mode_d = MD_SPARE; cyc_d = 2'd0; end
        default:     err_d = 1'b1;
      endcase
    end else if (addr_ev) begin
      if (mode_q == MD_IDLE) begin
        err_d = 1'b1;
      end else begin
        case (cyc_q)
          2'd0: begin ptr_d = PTR_W'(col_w); cyc_d = 2'd1; end
          2'd1: begin ptr_d = PTR_W'(ptr_w + 32'(byte_in) * 32'(ROW_HI)); cyc_d = 2'd2; end
          2'd2: begin ptr_d = PTR_W'(ptr_w + 32'(byte_in) * 32'(ROW_LO)); cyc_d = 2'd3; end
          default: err_d = 1'b1;
        endcase
      end
    end else if (rd_ev) begin
      ptr_d = ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_IDLE;
      cyc_q  <= 2'd0;
      ptr_q  <= '0;
      err_q  <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      cyc_q  <= cyc_d;
      ptr_q  <= ptr_d;
      err_q  <= err_d;
      rdy_q  <= rdy_d;
    end
  end

  assign ptr   = ptr_q;
  assign ready = rdy_q;
  assign err   = err_q;

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);

  // R7
  rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |=> rdy_q);

  // R8
  mode_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> $past(cmd_ev));

  // R11
  ptr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q != $past(ptr_q)) |-> $past(addr_ev || rd_ev));

  // R10
  rd_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && !cmd_ev && !addr_ev) |=> (ptr_q == PTR_W'($past(ptr_q) + PTR_W'(1))));

endmodule

// File: rtl/nandr_store.sv
module nandr_store #(
  parameter int PTR_W      = 16,
  parameter int FILL_LIMIT = 32768
) (
  input  logic [PTR_W-1:0] ptr,
  output logic [7:0]       data
);
  import nandr_pkg::*;

  always_comb begin
    if (32'(ptr) < 32'(FILL_LIMIT)) data = fold_byte(32'(ptr));
    else                            data = ERASED_BYTE;
  end

endmodule

// File: rtl/nandr_read_model.sv
module nandr_read_model #(
  parameter int PTR_W       = 16,
  parameter int FILL_LIMIT  = 32768,
  parameter int PAGE_BYTES  = 528,
  parameter int PLANE_PAGES = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce1_n,
  input  logic       ce2_n,
  input  logic       re_n,
  input  logic       we_n,
  input  logic       ale,
  input  logic       cle,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       dout_en,
  output logic [1:0] ready,
  output logic [1:0] proto_err
);

  localparam int N_DIE    = 2;
  localparam int HALF_COL = PAGE_BYTES / 2 - 8;   // 256 for a 528-byte page

  logic [1:0]       rst_sync;
  logic             rst_ns;
  logic             sel_vld, sel_dev, cmd_ev, addr_ev, rd_ev, rel_ev, wr_dev;
  logic [7:0]       wr_byte;
  logic [PTR_W-1:0] ptr_arr [N_DIE];
  logic [PTR_W-1:0] rd_ptr;
  logic [7:0]       rd_byte;
  logic [7:0]       dout_q, dout_d;
  logic             en_q, en_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  nandr_bus_sampler u_sampler (
    .clk     (clk),
    .rst_n   (rst_ns),
    .ce1_n   (ce1_n),
    .ce2_n   (ce2_n),
    .re_n    (re_n),
    .we_n    (we_n),
    .ale     (ale),
    .cle     (cle),
    .din     (din),
    .sel_vld (sel_vld),
    .sel_dev (sel_dev),
    .cmd_ev  (cmd_ev),
    .addr_ev (addr_ev),
    .rd_ev   (rd_ev),
    .rel_ev  (rel_ev),
    .wr_dev  (wr_dev),
    .wr_byte (wr_byte)
  );

  for (genvar k = 0; k < N_DIE; k++) begin : g_die
    logic is_wr, is_sel;
    assign is_wr  = (wr_dev == 1'(k));
    assign is_sel = sel_vld && (sel_dev == 1'(k));

    nandr_dev_core #(
      .PTR_W       (PTR_W),
      .PAGE_BYTES  (PAGE_BYTES),
      .PLANE_PAGES (PLANE_PAGES),
      .HALF_COL    (HALF_COL)
    ) u_core (
      .clk     (clk),
      .rst_n   (rst_ns),
      .cmd_ev  (cmd_ev && is_wr),
      .addr_ev (addr_ev && is_wr),
      .rd_ev   (rd_ev && is_sel),
      .rel_sel (rel_ev && is_sel),
      .byte_in (wr_byte),
      .ptr     (ptr_arr[k]),
      .ready   (ready[k]),
      .err     (proto_err[k])
    );
  end

  assign rd_ptr = ptr_arr[sel_dev];

  nandr_store #(
    .PTR_W      (PTR_W),
    .FILL_LIMIT (FILL_LIMIT)
  ) u_store (
    .ptr  (rd_ptr),
    .data (rd_byte)
  );

  always_comb begin
    dout_d = dout_q;
    en_d   = en_q;
    if (rd_ev) begin
      dout_d = rd_byte;
      en_d   = 1'b1;
    end else if (rel_ev) begin
      en_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      dout_q <= 8'h00;
      en_q   <= 1'b0;
    end else begin
      dout_q <= dout_d;
      en_q   <= en_d;
    end
  end

  assign dout    = dout_q;
  assign dout_en = en_q;

  // R4
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (en_q && !rd_ev) |=> $stable(dout_q));

  // R6
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!sel_vld && !en_q) |=> !en_q);

endmodule

// File: tb/nandr_read_model_bench.sv
module nandr_read_model_bench;

  localparam int CLK_PERIOD = 10;
  localparam int FILL       = 32768;
  localparam int PMASK      = 16'hFFFF;

  typedef struct {
    logic [7:0] v;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce1_n = 1'b1, ce2_n = 1'b1, re_n = 1'b1, we_n = 1'b1;
  logic       ale = 1'b0, cle = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       dout_en;
  logic [1:0] ready, proto_err;

  int   checks = 0;
  int   errs = 0;
  bit   done = 1'b0;
  exp_t sb_q[$];
  event sample_ev;

  int mode_m[2];
  int cyc_m[2];
  int ptr_m[2];
  int err_m[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  nandr_read_model u_nandr_read_model (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .re_n(re_n),
    .we_n(we_n), .ale(ale), .cle(cle), .din(din), .dout(dout),
    .dout_en(dout_en), .ready(ready), .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // R5 image model
  function automatic logic [7:0] content(input int p);
    logic [15:0] q;
    q = 16'(p);
    if (p < FILL) return q[7:0] ^ q[15:8] ^ 8'h5A;
    return 8'hFF;
  endfunction

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cycle(input logic c1, input logic c2, input logic c, input logic a, input logic [7:0] b);
    ce1_n = c1; ce2_n = c2; cle = c; ale = a; din = b; we_n = 1'b0;
    hold(3);
    we_n = 1'b1;
    hold(3);
    cle = 1'b0; ale = 1'b0;
    hold(1);
  endtask

  task automatic send_cmd(input logic c1, input logic c2, input int d, input logic [7:0] b);
    wr_cycle(c1, c2, 1'b1, 1'b0, b);
    case (b)
      8'hFF: mode_m[d] = 0;
      8'h00: begin mode_m[d] = 1; cyc_m[d] = 0; end
      8'h01: begin mode_m[d] = 2; cyc_m[d] = 0; end
      8'h50: begin mode_m[d] = 3; cyc_m[d] = 0; end
      default: err_m[d] = 1;
    endcase
  endtask

  task automatic send_addr(input logic c1, input logic c2, input int d, input logic [7:0] b);
    int off;
    wr_cycle(c1, c2, 1'b0, 1'b1, b);
    off = (mode_m[d] == 2) ? 'h100 : (mode_m[d] == 3) ? 'h200 : 0;
    if (mode_m[d] == 0) err_m[d] = 1;
    else begin
      case (cyc_m[d])
        0: ptr_m[d] = int'(b) | off;
        1: ptr_m[d] = (ptr_m[d] + int'(b) * 528 * 256) & PMASK;
        2: ptr_m[d] = (ptr_m[d] + int'(b) * 528) & PMASK;
        default: err_m[d] = 1;
      endcase
      if (cyc_m[d] < 3) cyc_m[d]++;
    end
  endtask

  task automatic seek(input logic c1, input logic c2, input int d, input logic [7:0] op,
                      input logic [7:0] a0, input logic [7:0] a1, input logic [7:0] a2);
    send_cmd(c1, c2, d, op);
    send_addr(c1, c2, d, a0);
    send_addr(c1, c2, d, a1);
    send_addr(c1, c2, d, a2);
  endtask

  // driver side of the scoreboard
  task automatic rd(input logic c1, input logic c2, input int d, input string tag);
    exp_t e;
    ce1_n = c1; ce2_n = c2; re_n = 1'b0;
    if (d >= 0) begin
      e.v = content(ptr_m[d]);
      e.tag = tag;
      sb_q.push_back(e);
      ptr_m[d] = (ptr_m[d] + 1) & PMASK;
    end
    hold(3);
    if (d >= 0) -> sample_ev;
    else chk(dout_en == 1'b0, tag, int'(dout_en), 0);
    hold(1);
    re_n = 1'b1;
    hold(3);
  endtask

  // monitor side of the scoreboard
  initial begin
    exp_t e;
    forever begin
      @(sample_ev);
      if (sb_q.size() == 0) chk(1'b0, "monitor-empty", 0, 1);
      else begin
        e = sb_q.pop_front();
        chk(dout_en === 1'b1 && dout === e.v, e.tag, int'(dout), int'(e.v));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      mode_m[i] = 0; cyc_m[i] = 0; ptr_m[i] = 0; err_m[i] = 0;
    end
    hold(3);
    // R1 reset state during reset
    chk(dout_en == 0 && ready == 0 && proto_err == 0, "R1 in reset",
        int'({dout_en, ready, proto_err}), 0);
    rst_n = 1'b1;
    hold(4);
    chk(dout_en == 0 && ready == 0 && proto_err == 0, "R1 after release",
        int'({dout_en, ready, proto_err}), 0);

    // R7 / R12: ready of die 0 due two edges after selection
    ce1_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(ready == 2'b00, "R12 ready not yet", int'(ready), 0);
    @(posedge clk); @(negedge clk);
    chk(ready == 2'b01, "R7 R12 ready die0", int'(ready), 1);
    hold(2);

    // R2 R3 R5 mode A, sequential reads
    seek(1'b0, 1'b1, 0, 8'h00, 8'h12, 8'h00, 8'h00);
    rd(1'b0, 1'b1, 0, "R2 R3 modeA byte0");
    rd(1'b0, 1'b1, 0, "R4 R5 modeA byte1");
    rd(1'b0, 1'b1, 0, "R4 modeA byte2");
    chk(dout_en == 1'b0, "R4 bus released", int'(dout_en), 0);

    // R3 mode B with row bytes
    seek(1'b0, 1'b1, 0, 8'h01, 8'h05, 8'h01, 8'h02);
    rd(1'b0, 1'b1, 0, "R3 modeB");
    // R3 mode C
    seek(1'b0, 1'b1, 0, 8'h50, 8'h10, 8'h00, 8'h03);
    rd(1'b0, 1'b1, 0, "R3 modeC");

    // R11 die 1 independent
    ce1_n = 1'b1; ce2_n = 1'b0; hold(3);
    chk(ready == 2'b11, "R7 ready die1", int'(ready), 3);
    seek(1'b1, 1'b0, 1, 8'h00, 8'h40, 8'h02, 8'h05);
    rd(1'b1, 1'b0, 1, "R11 die1 read");
    rd(1'b0, 1'b1, 0, "R11 die0 pointer kept");

    // R6 priority and ignore when deselected
    rd(1'b0, 1'b0, 0, "R6 ce1 wins");
    rd(1'b1, 1'b1, -1, "R6 deselected no drive");
    wr_cycle(1'b1, 1'b1, 1'b1, 1'b0, 8'h90);
    chk(proto_err == 2'b00, "R6 deselected cmd ignored", int'(proto_err), 0);
    rd(1'b0, 1'b1, 0, "R6 pointer unchanged");

    // R8 latch precedence: cle+ale with 0x01 acts as a command
    wr_cycle(1'b0, 1'b1, 1'b1, 1'b1, 8'h01);
    mode_m[0] = 2; cyc_m[0] = 0;
    send_addr(1'b0, 1'b1, 0, 8'h20);
    send_addr(1'b0, 1'b1, 0, 8'h00);
    send_addr(1'b0, 1'b1, 0, 8'h01);
    rd(1'b0, 1'b1, 0, "R8 cle over ale");
    // R8 write pulse without latch changes nothing
    wr_cycle(1'b0, 1'b1, 1'b0, 1'b0, 8'h33);
    rd(1'b0, 1'b1, 0, "R8 plain write ignored");

    // R9 unknown command on die 1; die keeps working
    send_cmd(1'b1, 1'b0, 1, 8'h90);
    chk(proto_err == 2'b10, "R9 unknown cmd", int'(proto_err), 2);
    rd(1'b1, 1'b0, 1, "R9 die1 still reads");
    // R9 fourth address byte on die 0
    send_addr(1'b0, 1'b1, 0, 8'h07);
    chk(proto_err == 2'b11, "R9 fourth addr", int'(proto_err), 3);
    rd(1'b0, 1'b1, 0, "R9 pointer untouched by fourth addr");
    // R2 reset command then address while idle
    send_cmd(1'b0, 1'b1, 0, 8'hFF);
    send_addr(1'b0, 1'b1, 0, 8'h44);
    rd(1'b0, 1'b1, 0, "R2 idle addr ignored");

    // R5 fill boundary 32767 -> 32768
    seek(1'b0, 1'b1, 0, 8'h01, 8'h8F, 8'h07, 8'h07);
    chk(ptr_m[0] == 32767, "R5 model pointer", ptr_m[0], 32767);
    rd(1'b0, 1'b1, 0, "R5 last filled");
    rd(1'b0, 1'b1, 0, "R5 erased 0xFF");

    // R10 wrap of increment 0xFFFF -> 0
    seek(1'b0, 1'b1, 0, 8'h01, 8'h8F, 8'h0F, 8'h07);
    rd(1'b0, 1'b1, 0, "R10 at 0xFFFF");
    rd(1'b0, 1'b1, 0, "R10 wrapped to 0");
    // R10 wrap inside address sum
    seek(1'b0, 1'b1, 0, 8'h50, 8'hFF, 8'h0F, 8'h07);
    rd(1'b0, 1'b1, 0, "R10 sum wraps");

    chk(ready == 2'b11, "R7 ready never falls", int'(ready), 3);
    chk(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule